// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits between a 16-bit processor core and a shared external bus. On that bus the low sixteen lines carry first an address and then data. The four upper lines carry first address bits 19..16 and then cycle status. The core hands over one transfer at a time. A transfer gives a 20-bit address, a byte or word size, a memory or IO space flag, a read or write direction, the segment register in use and the write data. A transfer can instead ask for an interrupt acknowledge. The sequencer then steps the bus through T1, T2, T3, any number of wait states (TW) and T4. In each state it drives the pins with what that state requires and inserts wait states while the addressed device holds ready low.

A word transfer to an odd address becomes two byte cycles. The odd byte goes first, then the even byte at the next address. An interrupt acknowledge always takes two bus cycles, and the vector byte is taken from the second one. Between bus cycles an external master may request the bus. Once the request is granted, every output enable drops until the request is withdrawn. Tri-state behaviour is modelled with a separate output-enable signal beside each driven pin group.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1 the AD lines are enabled and carry bits 15..0 of the cycle address. In every state of an interrupt-acknowledge cycle, and in idle, the AD enable is low.
- R2: In T1 `ahs_out` carries address bits 19..16 for memory cycles and 0 for IO and interrupt-acknowledge cycles.
- R3: From T2 to T4 `ahs_out` = {0, S5, seg[1:0]}. Bit 2 (S5) is the interrupt-enable input registered once per clock. The segment code is 00 extra, 01 stack, 10 code, 11 data. Interrupt acknowledge always reports 10.
- R4: In T1 `bhe_n` together with AD[0] encodes the transfer: {bhe_n, A0} = 00 whole word, 01 odd (upper) byte, 10 even (lower) byte. From T2 to T4 `bhe_n` carries status S7, which is 0.
- R5: `rd_n` is low exactly in T2, T3 and TW of memory or IO reads. Whenever `rd_n` is low the AD enable is low. At most one of `rd_n`, `wr_n` and `inta_n` is low at a time.
- R6: For a write, `wr_n` is low in T2, T3 and TW, and the AD lines are enabled with data from T2 through T4. A whole word appears as written. A byte appears on both lanes: write-data bits 7..0 for the first or only cycle, and bits 15..8 for the second cycle of a split.
- R7: `ready` is sampled at the end of T3 and of each TW. Low gives another TW, and high gives T4. The strobes are inactive in T4.
- R8: A word access at an odd address A runs as an upper-byte cycle at A followed by a lower-byte cycle at A+1, with the address wrapping modulo 2^20.
- R9: `op_done` is high in the final T4 of a transfer. There `rd_data` holds the read result: a word as read; a byte zero-extended, taken from AD[15:8] for an odd address and AD[7:0] for an even one; a split word as {second cycle AD[7:0], first cycle AD[15:8]}.
- R10: An interrupt acknowledge runs two bus cycles with `inta_n` low in T2, T3 and TW of each. `bhe_n` is 0 in T1 of the first cycle and 1 in T1 of the second. The result is {8'h00, AD[7:0] of the second cycle}.
- R11: A hold request is granted (`hold_ack` high the next cycle) only from idle or T4, including between the two cycles of a split. While granted, all output enables are low. One cycle after the request drops, `hold_ack` is low and the pins are driven again. A pending second cycle then resumes.
- R12: `req_accept` is high only in idle, with no hold request and no pending second cycle. T1 follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core has a transfer waiting |
| req_addr | input | 20 | Transfer address |
| req_word | input | 1 | 1 word, 0 byte |
| req_io | input | 1 | 1 IO space, 0 memory |
| req_write | input | 1 | 1 write, 0 read |
| req_inta | input | 1 | Interrupt acknowledge request |
| req_seg | input | 2 | Segment code in use |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | Transfer taken this cycle |
| rd_data | output | 16 | Read result |
| op_done | output | 1 | Final T4 of the transfer |
| ie_flag | input | 1 | Interrupt-enable flag of the core |
| ready | input | 1 | Device ready |
| hold_req | input | 1 | External bus request |
| hold_ack | output | 1 | Bus granted away |
| ad_in | input | 16 | Value read from the AD lines |
| ad_out | output | 16 | Value driven onto the AD lines |
| ad_oe | output | 1 | AD drive enable |
| ahs_out | output | 4 | Upper address / status lines |
| ahs_oe | output | 1 | Upper-line drive enable |
| bhe_n | output | 1 | Byte-high enable / S7 |
| bhe_oe | output | 1 | Byte-high enable drive enable |
| rd_n | output | 1 | Read strobe, active low |
| rd_oe | output | 1 | Read strobe drive enable |
| wr_n | output | 1 | Write strobe, active low |
| wr_oe | output | 1 | Write strobe drive enable |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| inta_oe | output | 1 | Interrupt acknowledge strobe drive enable |

## Verification
All pin values come from decode of registered state, so each result is due exactly one clock after the edge that enters its state. T1 pins appear one cycle after `req_accept`. Strobes appear one cycle later. `rd_data` is captured on the edge that leaves T3 or the last TW, so it is valid during T4. `hold_ack` follows the first idle or T4 edge that sees the request. The bench drives every input on the falling edge and samples the outputs at the next falling edge, half a period after the state register moves. It then walks the same state order the requirements give, counting the wait states it asked for.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int BW     = DATA_W / 2;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4,
        ST_HOLD
    } bus_st_e;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_STACK = 2'b01,
        SEG_CODE  = 2'b10,
        SEG_DATA  = 2'b11
    } seg_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic              io;
        logic              wr;
        logic              inta;
        seg_e              seg;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // transfer needs two bus cycles
    function automatic logic two_part(input bus_req_t r);
        return r.inta | (r.word & r.addr[0]);
    endfunction

    // states in which strobes are active
    function automatic logic strobe_phase(input bus_st_e s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
    endfunction

    // states after T1 of a cycle
    function automatic logic data_phase(input bus_st_e s);
        return strobe_phase(s) || (s == ST_T4);
    endfunction

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  bus_req_t          req_in,
    input  logic              ready,
    input  logic              hold_req,
    input  logic [DATA_W-1:0] ad_in,
    output bus_st_e           st,
    output bus_req_t          cur,
    output logic              second,
    output logic              req_accept,
    output logic              op_done,
    output logic [DATA_W-1:0] rd_data
);

    bus_st_e nxt;
    logic    pend;
    logic    first_of_two;
    logic    sample_now;

    assign first_of_two = two_part(cur) && !second;
    assign req_accept   = (st == ST_IDLE) && !hold_req && !pend && req_valid;
    assign op_done      = (st == ST_T4) && !first_of_two;
    assign sample_now   = ((st == ST_T3) || (st == ST_TW)) && ready;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (hold_req)               nxt = ST_HOLD;
                else if (pend || req_valid) nxt = ST_T1;
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3,
            ST_TW:   nxt = ready ? ST_T4 : ST_TW;
            ST_T4: begin
                if (hold_req)          nxt = ST_HOLD;
                else if (first_of_two) nxt = ST_T1;
                else                   nxt = ST_IDLE;
            end
            ST_HOLD: nxt = hold_req ? ST_HOLD : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur     <= '0;
            second  <= 1'b0;
            pend    <= 1'b0;
            rd_data <= '0;
        end else begin
            st <= nxt;
            if (req_accept) begin
                cur    <= req_in;
                second <= 1'b0;
            end
            if ((st == ST_T4) && first_of_two) begin
                second <= 1'b1;
                pend   <= hold_req;
            end
            if ((st == ST_IDLE) && pend && !hold_req)
                pend <= 1'b0;
            if (sample_now && (!cur.wr || cur.inta)) begin
                if (cur.inta) begin
                    if (second)
                        rd_data <= {{BW{1'b0}}, ad_in[BW-1:0]};
                end else if (two_part(cur)) begin
                    if (second) rd_data[DATA_W-1:BW] <= ad_in[BW-1:0];
                    else        rd_data[BW-1:0]      <= ad_in[DATA_W-1:BW];
                end else if (cur.word) begin
                    rd_data <= ad_in;
                end else begin
                    rd_data <= {{BW{1'b0}},
                                cur.addr[0] ? ad_in[DATA_W-1:BW] : ad_in[BW-1:0]};
                end
            end
        end
    end

    AST_WAIT_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_T3 || st == ST_TW) && !ready) |=> (st == ST_TW)); // R7
    AST_T4_ON_READY: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_T3 || st == ST_TW) && ready) |=> (st == ST_T4)); // R7
    AST_HOLD_ONLY_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && st != ST_T4 && st != ST_HOLD) |=> (st != ST_HOLD)); // R11
    AST_ACCEPT_T1: assert property (@(posedge clk) disable iff (rst)
        req_accept |=> (st == ST_T1)); // R12

endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
    import mbs_pkg::*;
(
    input  bus_st_e           st,
    input  bus_req_t          cur,
    input  logic              second,
    input  logic              ie_q,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   ahs_out,
    output logic              ahs_oe,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic              rd_n,
    output logic              rd_oe,
    output logic              wr_n,
    output logic              wr_oe,
    output logic              inta_n,
    output logic              inta_oe
);

    logic [ADDR_W-1:0] cyc_addr;
    logic              lane_a0;
    logic              eff_word;
    logic              bhe_t1;
    logic [DATA_W-1:0] wr_lanes;
    logic [HI_W-1:0]   status;
    seg_e              seg_code;

    assign cyc_addr = (second && !cur.inta) ? cur.addr + ADDR_W'(1) : cur.addr;
    assign lane_a0  = second ? 1'b0 : cur.addr[0];
    assign eff_word = cur.word & ~cur.addr[0];
    assign bhe_t1   = cur.inta ? second : ~(eff_word | lane_a0);
    assign seg_code = cur.inta ? SEG_CODE : cur.seg;
    assign status   = {1'b0, ie_q, seg_code};

    always_comb begin
        if (eff_word)    wr_lanes = cur.wdata;
        else if (second) wr_lanes = {2{cur.wdata[DATA_W-1:BW]}};
        else             wr_lanes = {2{cur.wdata[BW-1:0]}};
    end

    always_comb begin
        ad_out  = '0;
        ad_oe   = 1'b0;
        ahs_out = '0;
        ahs_oe  = 1'b1;
        bhe_n   = 1'b1;
        bhe_oe  = 1'b1;
        rd_n    = 1'b1;
        rd_oe   = 1'b1;
        wr_n    = 1'b1;
        wr_oe   = 1'b1;
        inta_n  = 1'b1;
        inta_oe = 1'b1;
        if (st == ST_HOLD) begin
            ahs_oe  = 1'b0;
            bhe_oe  = 1'b0;
            rd_oe   = 1'b0;
            wr_oe   = 1'b0;
            inta_oe = 1'b0;
        end else if (st == ST_T1) begin
            ad_oe   = !cur.inta;
            ad_out  = cyc_addr[DATA_W-1:0];
            ahs_out = (cur.io || cur.inta) ? '0 : cyc_addr[ADDR_W-1:DATA_W];
            bhe_n   = bhe_t1;
        end else if (data_phase(st)) begin
            ahs_out = status;
            bhe_n   = 1'b0;
            ad_oe   = cur.wr && !cur.inta;
            ad_out  = (cur.wr && !cur.inta) ? wr_lanes : '0;
            if (strobe_phase(st)) begin
                rd_n   = cur.wr || cur.inta;
                wr_n   = !(cur.wr && !cur.inta);
                inta_n = !cur.inta;
            end
        end
    end

    AST_RD_AD_RELEASED: assert final (rst_free_check(rd_n, ad_oe)); // R5
    AST_ONE_STROBE: assert final ($countones({~rd_n, ~wr_n, ~inta_n}) <= 1); // R5

    function automatic logic rst_free_check(input logic rdn, input logic adoe);
        return rdn || !adoe;
    endfunction

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [19:0] req_addr,
    input  logic        req_word,
    input  logic        req_io,
    input  logic        req_write,
    input  logic        req_inta,
    input  logic [1:0]  req_seg,
    input  logic [15:0] req_wdata,
    output logic        req_accept,
    output logic [15:0] rd_data,
    output logic        op_done,
    input  logic        ie_flag,
    input  logic        ready,
    input  logic        hold_req,
    output logic        hold_ack,
    input  logic [15:0] ad_in,
    output logic [15:0] ad_out,
    output logic        ad_oe,
    output logic [3:0]  ahs_out,
    output logic        ahs_oe,
    output logic        bhe_n,
    output logic        bhe_oe,
    output logic        rd_n,
    output logic        rd_oe,
    output logic        wr_n,
    output logic        wr_oe,
    output logic        inta_n,
    output logic        inta_oe
);

    bus_req_t req_in;
    bus_req_t cur;
    bus_st_e  st;
    logic     second;
    logic     ie_q;

    assign req_in = '{addr: req_addr, word: req_word, io: req_io, wr: req_write,
                      inta: req_inta, seg: seg_e'(req_seg), wdata: req_wdata};
    assign hold_ack = (st == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) ie_q <= 1'b0;
        else     ie_q <= ie_flag;
    end

    mbs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_in     (req_in),
        .ready      (ready),
        .hold_req   (hold_req),
        .ad_in      (ad_in),
        .st         (st),
        .cur        (cur),
        .second     (second),
        .req_accept (req_accept),
        .op_done    (op_done),
        .rd_data    (rd_data)
    );

    mbs_pins u_pins (
        .st      (st),
        .cur     (cur),
        .second  (second),
        .ie_q    (ie_q),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ahs_out (ahs_out),
        .ahs_oe  (ahs_oe),
        .bhe_n   (bhe_n),
        .bhe_oe  (bhe_oe),
        .rd_n    (rd_n),
        .rd_oe   (rd_oe),
        .wr_n    (wr_n),
        .wr_oe   (wr_oe),
        .inta_n  (inta_n),
        .inta_oe (inta_oe)
    );

    AST_HOLD_FLOATS: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> (!ad_oe && !ahs_oe && !bhe_oe && !rd_oe && !wr_oe)); // R11
    AST_INTA_NO_AD: assert property (@(posedge clk) disable iff (rst)
        !inta_n |-> !ad_oe); // R10

endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_io = 1'b0;
    logic        req_write = 1'b0;
    logic        req_inta = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_wdata = '0;
    logic        req_accept;
    logic [15:0] rd_data;
    logic        op_done;
    logic        ie_flag = 1'b0;
    logic        ready = 1'b1;
    logic        hold_req = 1'b0;
    logic        hold_ack;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  ahs_out;
    logic        ahs_oe;
    logic        bhe_n;
    logic        bhe_oe;
    logic        rd_n;
    logic        rd_oe;
    logic        wr_n;
    logic        wr_oe;
    logic        inta_n;
    logic        inta_oe;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    mux_bus_seq u_mux_bus_seq (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_op(input logic [19:0] addr, input logic word, input logic io,
                         input logic wr, input logic inta, input logic [1:0] seg,
                         input logic [15:0] wdata, input int nwait, input logic hold_mid,
                         input logic [15:0] rdv0, input logic [15:0] rdv1);
        int          halves;
        logic [15:0] exp_rd;
        logic        split;
        split  = word && addr[0] && !inta;
        halves = (inta || split) ? 2 : 1;
        exp_rd = 16'h0;
        @(negedge clk);
        req_addr = addr; req_word = word; req_io = io; req_write = wr;
        req_inta = inta; req_seg = seg; req_wdata = wdata; req_valid = 1'b1;
        #1;
        check("R12 accept in idle", req_accept, 1);
        tick();
        req_valid = 1'b0;
        for (int h = 0; h < halves; h++) begin
            logic [19:0] ca;
            logic        ebhe;
            logic [15:0] ewd;
            logic        is_rd;
            ca    = (h == 1 && !inta) ? addr + 20'd1 : addr;
            ebhe  = inta ? logic'(h) : !((word && !addr[0]) || (h == 0 && addr[0]));
            ewd   = (word && !addr[0]) ? wdata :
                    (h == 1) ? {wdata[15:8], wdata[15:8]} : {wdata[7:0], wdata[7:0]};
            is_rd = !wr && !inta;
            // T1
            check(inta ? "R10 AD float in T1" : "R1 AD enable in T1", ad_oe, !inta);
            if (!inta) check(split ? "R8 split cycle address" : "R1 T1 address", ad_out, ca[15:0]);
            check("R2 upper lines in T1", ahs_out, (io || inta) ? 4'h0 : ca[19:16]);
            check(inta ? "R10 bhe in T1" : "R4 bhe in T1", bhe_n, ebhe);
            check("R5 no read strobe in T1", rd_n, 1);
            // T2
            ready = (nwait == 0);
            ad_in = (h == 0) ? rdv0 : rdv1;
            tick();
            check("R3 status in T2", ahs_out, {1'b0, ie_flag, inta ? 2'b10 : seg});
            check("R4 S7 in T2", bhe_n, 0);
            check("R5 read strobe in T2", rd_n, !is_rd);
            check("R6 write strobe in T2", wr_n, !(wr && !inta));
            check("R10 inta strobe in T2", inta_n, !inta);
            check("R6 AD enable in T2", ad_oe, wr && !inta);
            if (wr) check("R6 write data in T2", ad_out, ewd);
            // T3
            tick();
            if (hold_mid && h == 0) hold_req = 1'b1;
            check("R5 read strobe in T3", rd_n, !is_rd);
            for (int w = 0; w < nwait; w++) begin
                tick();
                check("R7 strobe held in TW", {rd_n, wr_n, inta_n},
                      {!is_rd, !(wr && !inta), !inta});
                ready = (w == nwait - 1);
            end
            // T4
            tick();
            check("R7 strobes off in T4", {rd_n, wr_n, inta_n}, 3'b111);
            check("R6 AD enable in T4", ad_oe, wr && !inta);
            check("R11 no grant inside a cycle", hold_ack, 0);
            if (inta) begin
                if (h == 1) exp_rd = {8'h00, rdv1[7:0]};
            end else if (split) begin
                if (h == 0) exp_rd[7:0] = rdv0[15:8];
                else        exp_rd[15:8] = rdv1[7:0];
            end else if (word) begin
                exp_rd = rdv0;
            end else begin
                exp_rd = {8'h00, addr[0] ? rdv0[15:8] : rdv0[7:0]};
            end
            check("R9 done flag", op_done, (h == halves - 1));
            if (h == halves - 1 && !wr)
                check(inta ? "R10 vector" : "R9 read result", rd_data, exp_rd);
            if (h < halves - 1) begin
                tick();
                if (hold_mid) begin
                    check("R11 grant between halves", hold_ack, 1);
                    check("R11 pins float", {ad_oe, ahs_oe, bhe_oe, rd_oe, wr_oe}, 5'b0);
                    hold_req = 1'b0;
                    tick();
                    check("R11 release after one clock", {hold_ack, ahs_oe, rd_oe}, 3'b011);
                    check("R12 no accept with pending half", req_accept, 0);
                    tick();
                end
            end
        end
        @(posedge clk);
    endtask

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        check("R5 reset strobes", {rd_n, rd_oe, wr_n, inta_n}, 4'b1111);
        check("R1 reset AD released", ad_oe, 0);
        check("R11 reset no grant", hold_ack, 0);
        check("R9 reset result", {op_done, rd_data}, 17'h0);

        // sweep of alignment, size, direction, space
        for (int a = 0; a < 2; a++) begin
            for (int wd = 0; wd < 2; wd++) begin
                for (int wrv = 0; wrv < 2; wrv++) begin
                    for (int iov = 0; iov < 2; iov++) begin
                        int k;
                        k = a * 8 + wd * 4 + wrv * 2 + iov;
                        @(negedge clk);
                        ie_flag = logic'((wd + iov) % 2);
                        do_op(20'hA5F3E | 20'(a), logic'(wd), logic'(iov), logic'(wrv), 1'b0,
                              2'(k % 4), 16'(16'h1234 + k * 16'h0F1D), k % 3, 1'b0,
                              16'(16'hC3A0 + k * 16'h0111), 16'(16'h5B07 + k * 16'h0203));
                    end
                end
            end
        end

        // split with carry into upper address lines
        do_op(20'h0FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 16'h0, 1, 1'b0, 16'hAB12, 16'h34CD);
        do_op(20'h0FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 16'hBEEF, 0, 1'b0, 16'h0, 16'h0);

        // interrupt acknowledge pair
        do_op(20'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 16'h0, 1, 1'b0, 16'hFFFF, 16'h9942);

        // hold granted between halves of a split write
        do_op(20'h12345, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 16'hA55A, 2, 1'b1, 16'h0, 16'h0);

        // hold in idle blocks acceptance
        @(negedge clk);
        hold_req = 1'b1;
        req_valid = 1'b1;
        req_inta = 1'b0; req_write = 1'b0; req_word = 1'b0;
        #1;
        check("R12 no accept under hold", req_accept, 0);
        tick();
        check("R11 grant from idle", hold_ack, 1);
        check("R12 no accept while granted", req_accept, 0);
        req_valid = 1'b0;
        hold_req = 1'b0;
        tick();
        check("R11 drive resumes", {hold_ack, rd_oe, bhe_oe}, 3'b011);

        // S5 follows the interrupt flag one clock later
        ie_flag = 1'b1;
        do_op(20'h00400, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 16'h0, 0, 1'b0, 16'h7788, 16'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule